// File: doc/BRIEF.md
# Parallel ROM Read Sequencer

This block sits between a synchronous host and an asynchronous byte-wide read-only memory of 8192 locations. The host presents a 13-bit address with a request strobe while `ready` is high. The sequencer drives the address, pulls the active-low chip and output enables low together, and waits a fixed number of clock cycles. That wait is the larger of the address access time and the enable-to-data time, expressed in cycles. It then registers the byte on the data pins and returns it to the host with a one-cycle `rd_valid` pulse.

After the byte is captured, both enables go high again in the same cycle. The sequencer then holds `ready` low for the bus float time, so that the device has released the shared data lines before any new access starts. Between accesses the chip enable stays high, which keeps the device in its low-power standby mode. The programming strobe and programming-voltage request are tied to their inactive levels, so the device is only ever read.

All three device times are parameters counted in clock cycles, rounded up by the integrator. The capture point is never earlier than two cycles after the enables fall.

Top module: `prom_read_sequencer`

## Requirements
- R1: In reset and in the first cycle after it, `dev_ce_n` = 1, `dev_oe_n` = 1, `ready` = 1 and `rd_valid` = 0.
- R2: `dev_pgm_n` is always 1 and `dev_vpp_hi` is always 0.
- R3: A request is accepted at a rising edge where `req_valid` and `ready` are both 1. In the next cycle `ready` = 0, `dev_ce_n` = 0, `dev_oe_n` = 0, and `dev_addr` equals the accepted `req_addr`. `dev_addr` stays unchanged while `dev_ce_n` is 0.
- R4: The byte is sampled from `dev_data` at the edge that ends cycle CAP after acceptance, where CAP = max(T_ACC, T_OE, 2). `rd_valid` is 1 in cycle CAP+1, and `rd_data` then equals the device byte at the accepted address.
- R5: `rd_valid` is high for exactly one cycle per accepted request. `rd_data` keeps its value until the next capture.
- R6: In the cycle where `rd_valid` is 1, `dev_oe_n` and `dev_ce_n` are already 1. The output enable is never released before the capture.
- R7: After the enables rise, `ready` stays 0 for FLT = max(T_FLOAT, 1) cycles. `ready` returns in cycle CAP+FLT+1 after acceptance, when the device bus has floated.
- R8: Requests presented while `ready` = 0 are ignored. They cause no extra `rd_valid` and no change of `dev_addr`.
- R9: Whenever `ready` = 1, `dev_ce_n` and `dev_oe_n` are both 1 (standby).
- R10: Locations that hold no programmed bits return 0xFF unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | ADDR_W | Byte address of the request |
| ready | output | 1 | Sequencer idle, request will be accepted |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds the new byte |
| rd_data | output | DATA_W | Last captured byte |
| dev_addr | output | ADDR_W | Address pins of the device |
| dev_ce_n | output | 1 | Chip enable, active low |
| dev_oe_n | output | 1 | Output enable, active low |
| dev_pgm_n | output | 1 | Programming strobe, held inactive high |
| dev_vpp_hi | output | 1 | Programming-voltage request, held inactive low |
| dev_data | input | DATA_W | Data pins of the device |

## Verification
The hardest situation to produce is a capture one cycle too early. At the port level it only shows up as a wrong byte, because the device model drives X until both the access and the enable delays have run, and Z while the output enable is high. The stimulus reaches it by reading every address with a byte that differs from zero and from its neighbours, and by timing each `rd_valid` against the expected CAP count. A second difficult case is a request arriving during the float window. Some reads keep `req_valid` high through every busy cycle with a different address, and drop it in the cycle `ready` returns.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_CAPTURE,
        ST_RELEASE
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_IDLE   = '{ce_n: 1'b1, oe_n: 1'b1};
    localparam pin_ctl_t PINS_ACTIVE = '{ce_n: 1'b0, oe_n: 1'b0};

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // enable-low cycles up to and including the capture edge
    function automatic int unsigned cap_cycles(input int unsigned t_acc, input int unsigned t_oe);
        return max_u(max_u(t_acc, t_oe), 2);
    endfunction

    function automatic int unsigned float_cycles(input int unsigned t_flt);
        return max_u(t_flt, 1);
    endfunction

endpackage

// File: rtl/prom_cycle_timer.sv
module prom_cycle_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expire = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/prom_rd_datapath.sv
module prom_rd_datapath #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              capture,
    input  logic [DATA_W-1:0] dev_data,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              valid_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (accept) begin
                addr_q <= req_addr;
            end
            if (capture) begin
                data_q <= dev_data;
            end
            valid_q <= capture;
        end
    end
endmodule

// File: rtl/prom_seq_fsm.sv
module prom_seq_fsm
    import prom_rd_pkg::*;
#(
    parameter int WAIT_CYC  = 3,
    parameter int FLOAT_CYC = 2,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             timer_expire,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             accept,
    output logic             capture,
    output logic             ready,
    output pin_ctl_t         pins
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        accept     = 1'b0;
        capture    = 1'b0;
        ready      = 1'b0;
        pins       = PINS_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                ready = 1'b1;
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: begin
                pins = PINS_ACTIVE;
                if (WAIT_CYC == 0) begin
                    state_d = ST_CAPTURE;
                end else begin
                    timer_load = 1'b1;
                    timer_val  = CNT_W'(WAIT_CYC);
                    state_d    = ST_WAIT;
                end
            end
            ST_WAIT: begin
                pins = PINS_ACTIVE;
                if (timer_expire) begin
                    state_d = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                pins       = PINS_ACTIVE;
                capture    = 1'b1;
                timer_load = 1'b1;
                timer_val  = CNT_W'(FLOAT_CYC);
                state_d    = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (timer_expire) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/prom_read_sequencer.sv
module prom_read_sequencer
    import prom_rd_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 8,
    parameter int T_ACC   = 5,
    parameter int T_OE    = 3,
    parameter int T_FLOAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] dev_addr,
    output logic              dev_ce_n,
    output logic              dev_oe_n,
    output logic              dev_pgm_n,
    output logic              dev_vpp_hi,
    input  logic [DATA_W-1:0] dev_data
);
    localparam int CAP_CYC   = int'(cap_cycles(T_ACC, T_OE));
    localparam int WAIT_CYC  = CAP_CYC - 2;
    localparam int FLOAT_CYC = int'(float_cycles(T_FLOAT));
    localparam int CNT_MAX   = int'(max_u(WAIT_CYC, FLOAT_CYC));
    localparam int CNT_W     = $clog2(CNT_MAX + 1);

    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_expire;
    logic             accept;
    logic             capture;
    pin_ctl_t         pins;

    prom_seq_fsm #(
        .WAIT_CYC (WAIT_CYC),
        .FLOAT_CYC(FLOAT_CYC),
        .CNT_W    (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .timer_expire(timer_expire),
        .timer_load  (timer_load),
        .timer_val   (timer_val),
        .accept      (accept),
        .capture     (capture),
        .ready       (ready),
        .pins        (pins)
    );

    prom_cycle_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (timer_load),
        .load_val(timer_val),
        .expire  (timer_expire)
    );

    prom_rd_datapath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_dp (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .req_addr(req_addr),
        .capture (capture),
        .dev_data(dev_data),
        .addr_q  (dev_addr),
        .data_q  (rd_data),
        .valid_q (rd_valid)
    );

    assign dev_ce_n   = pins.ce_n;
    assign dev_oe_n   = pins.oe_n;
    assign dev_pgm_n  = 1'b1;
    assign dev_vpp_hi = 1'b0;
endmodule

// File: rtl/prom_rd_checks.sv
module prom_rd_checks #(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int CAP_CYC   = 5,
    parameter int FLOAT_CYC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              ready,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] dev_addr,
    input logic              dev_ce_n,
    input logic              dev_oe_n
);
    logic [7:0] act_cnt;
    logic [7:0] gap_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cnt <= '0;
            gap_cnt <= 8'hFF;
        end else begin
            if (dev_oe_n) act_cnt <= '0;
            else if (act_cnt != 8'hFF) act_cnt <= act_cnt + 1'b1;
            if (!dev_oe_n) gap_cnt <= '0;
            else if (gap_cnt != 8'hFF) gap_cnt <= gap_cnt + 1'b1;
        end
    end

    AST_STANDBY_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
        ready |-> (dev_ce_n && dev_oe_n)); // R9
    AST_ACCEPT_ENGAGES: assert property (@(posedge clk) disable iff (rst)
        (req_valid && ready) |=> (!ready && !dev_ce_n && !dev_oe_n && dev_addr == $past(req_addr))); // R3
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        !dev_ce_n |=> (dev_ce_n || $stable(dev_addr))); // R3
    AST_CAPTURE_TIMING: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (32'(act_cnt) == CAP_CYC)); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R5
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (!rd_valid && !$past(rst)) |-> $stable(rd_data)); // R5
    AST_OE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (dev_oe_n && dev_ce_n && !$past(dev_oe_n))); // R6
    AST_FLOAT_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> (32'(gap_cnt) >= FLOAT_CYC)); // R7
    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
        !ready |=> $stable(dev_addr)); // R8
endmodule

bind prom_read_sequencer prom_rd_checks #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CAP_CYC  (CAP_CYC),
    .FLOAT_CYC(FLOAT_CYC)
) u_checks (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .ready    (ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .dev_addr (dev_addr),
    .dev_ce_n (dev_ce_n),
    .dev_oe_n (dev_oe_n)
);

// File: tb/tb_prom_read_sequencer.sv
module tb_prom_read_sequencer;
    localparam int ADDR_W  = 13;
    localparam int DATA_W  = 8;
    localparam int T_ACC   = 5;
    localparam int T_OE    = 3;
    localparam int T_FLOAT = 2;
    localparam int EXP_CAP = (T_ACC > T_OE) ? ((T_ACC > 2) ? T_ACC : 2) : ((T_OE > 2) ? T_OE : 2);
    localparam int EXP_FLT = (T_FLOAT > 1) ? T_FLOAT : 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic              ready;
    logic              rd_valid;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] dev_addr;
    logic              dev_ce_n;
    logic              dev_oe_n;
    logic              dev_pgm_n;
    logic              dev_vpp_hi;
    logic [DATA_W-1:0] dev_bus;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    prom_read_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .T_ACC(T_ACC), .T_OE(T_OE), .T_FLOAT(T_FLOAT)
    ) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .ready(ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .dev_addr(dev_addr), .dev_ce_n(dev_ce_n), .dev_oe_n(dev_oe_n),
        .dev_pgm_n(dev_pgm_n), .dev_vpp_hi(dev_vpp_hi), .dev_data(dev_bus)
    );

    // device contents: upper quarter left blank (R10)
    function automatic logic [7:0] rom_byte(input logic [ADDR_W-1:0] a);
        if (a >= 13'h1800) return 8'hFF;
        return a[7:0] ^ {a[12:8], 3'b101};
    endfunction

    // behavioural device: counters advance on the falling edge
    int act_cnt = 0;
    int flt_cnt = 1000;
    always @(negedge clk) begin
        if (!dev_ce_n && !dev_oe_n) act_cnt <= act_cnt + 1;
        else act_cnt <= 0;
        if (!dev_oe_n) flt_cnt <= 0;
        else if (flt_cnt < 1000) flt_cnt <= flt_cnt + 1;
    end

    always_comb begin
        if (!dev_oe_n) begin
            if (!dev_ce_n && act_cnt >= T_ACC && act_cnt >= T_OE) dev_bus = rom_byte(dev_addr);
            else dev_bus = 'x;
        end else if (flt_cnt < T_FLOAT) begin
            dev_bus = 'x;
        end else begin
            dev_bus = 'z;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [ADDR_W-1:0] addr, input bit poke);
        int k;
        int extra;
        bit addr_held;
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        extra = 0;
        addr_held = 1'b1;
        chk(ready == 1'b0, "R3 ready low", 32'(ready), 0);
        chk(!dev_ce_n && !dev_oe_n, "R3 enables", {dev_ce_n, dev_oe_n}, 0);
        chk(dev_addr == addr, "R3 address", 32'(dev_addr), 32'(addr));
        while (!rd_valid && k < 300) begin
            if (poke) begin req_valid = 1'b1; req_addr = ~addr; end
            @(negedge clk);
            k++;
            if (dev_addr != addr) addr_held = 1'b0;
        end
        chk(k == EXP_CAP + 1, "R4 latency", 32'(k), 32'(EXP_CAP + 1));
        chk(!$isunknown(rd_data), "R4 known data", 32'(rd_data), 32'(rom_byte(addr)));
        chk(rd_data == rom_byte(addr), "R4 data", 32'(rd_data), 32'(rom_byte(addr)));
        chk(dev_ce_n && dev_oe_n, "R6 released", {dev_ce_n, dev_oe_n}, 3);
        if (poke) begin req_valid = 1'b1; req_addr = ~addr; end
        @(negedge clk);
        k++;
        chk(rd_valid == 1'b0, "R5 pulse", 32'(rd_valid), 0);
        while (!ready && k < 600) begin
            if (poke) begin req_valid = 1'b1; req_addr = ~addr; end
            @(negedge clk);
            k++;
            if (rd_valid) extra++;
            if (dev_addr != addr) addr_held = 1'b0;
        end
        req_valid = 1'b0;
        chk(k == EXP_CAP + EXP_FLT + 1, "R7 busy span", 32'(k), 32'(EXP_CAP + EXP_FLT + 1));
        chk(flt_cnt >= T_FLOAT, "R7 bus floated", 32'(flt_cnt), 32'(T_FLOAT));
        chk(rd_data == rom_byte(addr), "R5 held", 32'(rd_data), 32'(rom_byte(addr)));
        chk(dev_ce_n && dev_oe_n, "R9 standby", {dev_ce_n, dev_oe_n}, 3);
        if (poke) begin
            chk(extra == 0, "R8 no extra", 32'(extra), 0);
            chk(addr_held, "R8 addr held", 32'(dev_addr), 32'(addr));
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            vectors++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        rst = 1'b1;
        req_valid = 1'b0;
        req_addr = '0;
        repeat (4) @(negedge clk);
        chk(dev_ce_n && dev_oe_n, "R1 enables in reset", {dev_ce_n, dev_oe_n}, 3);
        chk(ready && !rd_valid, "R1 handshake in reset", {ready, rd_valid}, 2);
        rst = 1'b0;
        @(negedge clk);
        chk(dev_ce_n && dev_oe_n && ready && !rd_valid, "R1 after reset",
            {dev_ce_n, dev_oe_n, ready, rd_valid}, 4'hE);
        chk(dev_pgm_n == 1'b1 && dev_vpp_hi == 1'b0, "R2 prog pins", {dev_pgm_n, dev_vpp_hi}, 2);
        repeat (3) @(negedge clk);
        chk(dev_ce_n && dev_oe_n, "R9 idle standby", {dev_ce_n, dev_oe_n}, 3);

        do_read(13'h0000, 1'b0);
        do_read(13'h17FF, 1'b0);
        do_read(13'h1800, 1'b0);   // R10 first blank location
        do_read(13'h1FFF, 1'b1);   // R10 and R8
        do_read(13'h0A5A, 1'b1);   // R8
        do_read(13'h0001, 1'b0);   // back-to-back

        for (int i = 0; i < 40; i++) begin
            logic [ADDR_W-1:0] a;
            int gap;
            a = ADDR_W'($urandom);
            gap = int'($urandom % 4);
            repeat (gap) @(negedge clk);
            do_read(a, 1'($urandom % 2));
        end

        chk(dev_pgm_n == 1'b1 && dev_vpp_hi == 1'b0, "R2 prog pins at end", {dev_pgm_n, dev_vpp_hi}, 2);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule